// File: doc/BRIEF.md
# I2C Write-Only Target with Two Control Registers

This block is the serial control port of a device that holds two 8-bit configuration registers. A fast system clock oversamples SCL and SDA. The block detects START and STOP and checks the address byte against a 7-bit identity. The upper five bits of that identity are a fixed prefix, and the lower two come from strap pins. A matching write transfer is acknowledged. The next byte selects a register, and every byte after it is written into the register file.

The register pointer is one bit wide. After each stored data byte it flips, so a long burst alternates between the two registers. A read address that matches is acknowledged and then dropped, because no data leaves the block. Both register values are presented in parallel on `regs_o`: register 0 in bits 7:0 and register 1 in bits 15:8. The block drives SDA only through an active-low pull-down enable. The pad and the external pull-up form the wired-AND line.

Top module: `i2c_pair_reg_target`

## Requirements
- R1: After reset both registers read 0x00 and `sda_drive_no` is 1 (line released).
- R2: A START (SDA falling while SCL high) at any point, including in the middle of a byte or a transfer, restarts address reception from the first bit.
- R3: The address byte is received MSB first. Bits 7:3 must be 00100, bit 2 must equal `strap_i[1]`, bit 1 must equal `strap_i[0]`, and bit 0 is the direction (0 write, 1 read). On a match the block pulls SDA low during the ninth clock.
- R4: On an address mismatch SDA is never pulled low, and no later byte is acknowledged or stored until the next START.
- R5: The byte after a matched write address is the pointer. It is always acknowledged, only its bit 0 is used, and its upper bits are ignored.
- R6: Each byte after the pointer is received MSB first, stored in the register the pointer selects, and acknowledged.
- R7: After each stored data byte the pointer flips (0 to 1, 1 to 0). A transfer may carry any number of data bytes.
- R8: The pull-down is asserted only after the SCL falling edge that ends the eighth bit. It is released after the SCL falling edge that ends the ninth bit, and it is never active during data bits.
- R9: A matched read address is acknowledged. The block then ignores the bus until the next START, and no register changes.
- R10: A STOP (SDA rising while SCL high) releases SDA and returns the block to idle. Clocking after that without a START has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Pin-strapped low address bits; bit 1 is compared first |
| sda_drive_no | output | 1 | Active-low pull-down enable for SDA |
| regs_o | output | 16 | Register 1 in bits 15:8, register 0 in bits 7:0 |

## Verification
On every cycle the assertions check four things. The pull-down only ever appears while the bit counter sits in the acknowledge window. Registers hold while the controller is idle. START and STOP force the expected controller state with the drive released. The pointer steps once for each stored byte. Only the bench scenarios can show the rest: that real addresses match or fail on each bit, that bytes land in the right register in MSB-first order, that bursts alternate between the registers, and that a repeated START, a read address or an aborted transfer leave the expected register contents.

// File: rtl/i2c_pr_pkg.sv
package i2c_pr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA
  } ctl_st_e;
endpackage

// File: rtl/i2c_pr_sync.sv
module i2c_pr_sync (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       scl_rise_o,
  output logic       scl_fall_o,
  output logic       start_o,
  output logic       stop_o
);
  localparam int unsigned LINES = 2;
  localparam int unsigned DEPTH = 3;  // two sync flops + one history flop

  logic [LINES-1:0] raw;
  logic [DEPTH-1:0] pipe_q [LINES];

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= '1;
      else         pipe_q[i] <= {pipe_q[i][DEPTH-2:0], raw[i]};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = pipe_q[0][DEPTH-2];
  assign scl_old = pipe_q[0][DEPTH-1];
  assign sda_now = pipe_q[1][DEPTH-2];
  assign sda_old = pipe_q[1][DEPTH-1];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_pr_shifter.sv
module i2c_pr_shifter #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              byte_done_o,
  output logic              ack_done_o
);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  // cnt counts SCL rises: 1..BYTE_W data bits, BYTE_W+1 = ack clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      if (cnt_q < CNT_BYTE) sh_q <= {sh_q[BYTE_W-2:0], sda_i};
      if (cnt_q <= CNT_BYTE) cnt_q <= cnt_q + 1'b1;
    end else if (scl_fall_i && cnt_q == CNT_ACK) begin
      cnt_q <= '0;
    end
  end

  assign byte_o      = sh_q;
  assign cnt_o       = cnt_q;
  assign byte_done_o = scl_fall_i && cnt_q == CNT_BYTE;
  assign ack_done_o  = scl_fall_i && cnt_q == CNT_ACK;

  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_ACK);
endmodule

// File: rtl/i2c_pr_ctrl.sv
module i2c_pr_ctrl
  import i2c_pr_pkg::*;
#(
  parameter int unsigned          PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0]  PREFIX   = 5'b00100,
  parameter int unsigned          STRAP_W  = 2,
  parameter int unsigned          NREGS    = 2,
  parameter int unsigned          DATA_W   = 8,
  localparam int unsigned         ADDR_W   = PREFIX_W + STRAP_W,
  localparam int unsigned         PTR_W    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    byte_done_i,
  input  logic                    ack_done_i,
  input  logic [DATA_W-1:0]       byte_i,
  input  logic [STRAP_W-1:0]      strap_i,
  output logic                    ack_o,
  output logic [NREGS*DATA_W-1:0] regs_o
);
  ctl_st_e                         st_q;
  logic                            ack_q;
  logic [PTR_W-1:0]                ptr_q;
  logic [NREGS-1:0][DATA_W-1:0]    regs_q;
  logic [ADDR_W-1:0]               own_addr;
  logic                            addr_hit;

  assign own_addr = {PREFIX, strap_i};
  assign addr_hit = byte_i[DATA_W-1 -: ADDR_W] == own_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      ptr_q  <= '0;
      regs_q <= '0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      ack_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else if (byte_done_i) begin
      unique case (st_q)
        ST_ADDR: begin
          if (addr_hit) ack_q <= 1'b1;
          else          st_q  <= ST_IDLE;
        end
        ST_PTR: begin
          ptr_q <= byte_i[PTR_W-1:0];  // upper bits ignored
          ack_q <= 1'b1;
        end
        ST_DATA: begin
          regs_q[ptr_q] <= byte_i;
          ptr_q         <= ptr_q + 1'b1;
          ack_q         <= 1'b1;
        end
        default: ;
      endcase
    end else if (ack_done_i) begin
      ack_q <= 1'b0;
      unique case (st_q)
        ST_ADDR: st_q <= byte_i[0] ? ST_IDLE : ST_PTR;  // read: ack then drop
        ST_PTR:  st_q <= ST_DATA;
        default: ;
      endcase
    end
  end

  assign ack_o  = ack_q;
  assign regs_o = regs_q;

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> $stable(regs_q));

  assert_start_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_ADDR && !ack_q));

  assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (st_q == ST_IDLE && !ack_q));

  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !start_i && !stop_i && st_q == ST_DATA)
      |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/i2c_pair_reg_target.sv
module i2c_pair_reg_target
  import i2c_pr_pkg::*;
#(
  parameter int unsigned NREGS   = 2,
  parameter int unsigned STRAP_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [STRAP_W-1:0]      strap_i,
  output logic                    sda_drive_no,
  output logic [NREGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 2);

  logic sda_s, scl_rise, scl_fall, start, stop;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic byte_done, ack_done, ack;

  i2c_pr_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_pr_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_i       (sda_s),
    .byte_o      (rx_byte),
    .cnt_o       (bit_cnt),
    .byte_done_o (byte_done),
    .ack_done_o  (ack_done)
  );

  i2c_pr_ctrl #(
    .STRAP_W (STRAP_W),
    .NREGS   (NREGS),
    .DATA_W  (BYTE_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .byte_done_i (byte_done),
    .ack_done_i  (ack_done),
    .byte_i      (rx_byte),
    .strap_i     (strap_i),
    .ack_o       (ack),
    .regs_o      (regs_o)
  );

  assign sda_drive_no = ~ack;

  // pull-down only between the end of bit 8 and the end of the ack clock
  assert_ack_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_drive_no |-> (bit_cnt >= CNT_W'(BYTE_W)));
endmodule

// File: tb/i2c_pair_reg_target_test.sv
module i2c_pair_reg_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1;
  logic sda_d = 1'b1;
  logic [1:0] strap_d = 2'b10;
  logic sda_drive_n;
  logic [15:0] regs;
  logic sda_line;

  assign sda_line = sda_d & sda_drive_n;

  always #10 clk = ~clk;  // 50 MHz

  i2c_pair_reg_target uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_d),
    .sda_i        (sda_line),
    .strap_i      (strap_d),
    .sda_drive_no (sda_drive_n),
    .regs_o       (regs)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] m_reg [2];
  logic       m_ptr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_d = 1'b1; tick(5);
    scl_d = 1'b1; tick(5);
    sda_d = 1'b0; tick(5);
    scl_d = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    sda_d = 1'b0; tick(5);
    scl_d = 1'b1; tick(5);
    sda_d = 1'b1; tick(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_d = b[i]; tick(5);
      scl_d = 1'b1; tick(5);
      if (i == 0) check(sda_drive_n == 1'b1, "R8", "drive during bit 8", 32'(sda_drive_n), 1);
      tick(5);
      scl_d = 1'b0; tick(5);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    send_bits(b, 8);
    sda_d = 1'b1; tick(5);
    scl_d = 1'b1; tick(5);
    got = !sda_line;
    check(got == exp_ack, req, "ack", 32'(got), 32'(exp_ack));
    tick(5);
    scl_d = 1'b0; tick(5);
    check(sda_drive_n == 1'b1, "R8", "release after ack", 32'(sda_drive_n), 1);
  endtask

  task automatic wr_data(input logic [7:0] b);
    send_byte(b, 1'b1, "R6");
    m_reg[m_ptr] = b;
    m_ptr = ~m_ptr;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.val = {m_reg[1], m_reg[0]};
    e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  function automatic logic [7:0] own(input bit rw);
    return {5'b00100, strap_d, rw};
  endfunction

  // monitor: pops expected register images and compares
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() > 0);
      @(negedge clk);
      e = exp_q.pop_front();
      check(regs == e.val, e.tag, "regs", 32'(regs), 32'(e.val));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_ptr = 1'b0;
    tick(3);
    check(regs == 16'h0000, "R1", "reset regs", 32'(regs), 0);
    check(sda_drive_n == 1'b1, "R1", "reset drive", 32'(sda_drive_n), 1);
    rst_n = 1'b1;
    tick(5);
    check(regs == 16'h0000, "R1", "regs after reset", 32'(regs), 0);

    // R3 R6: basic write of both registers
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h00, 1'b1, "R5"); m_ptr = 1'b0;
    wr_data(8'hA5);
    wr_data(8'h3C);
    bus_stop();
    push_exp("R6");

    // R7: burst starting at register 1 wraps
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h01, 1'b1, "R5"); m_ptr = 1'b1;
    wr_data(8'h11);
    wr_data(8'h22);
    wr_data(8'h33);
    bus_stop();
    push_exp("R7");

    // R4: strap bits mismatch
    bus_start();
    send_byte({5'b00100, ~strap_d, 1'b0}, 1'b0, "R4");
    send_byte(8'h00, 1'b0, "R4");
    send_byte(8'hFF, 1'b0, "R4");
    bus_stop();
    push_exp("R4");

    // R4: prefix mismatch
    bus_start();
    send_byte({5'b10100, strap_d, 1'b0}, 1'b0, "R4");
    send_byte(8'h01, 1'b0, "R4");
    send_byte(8'hEE, 1'b0, "R4");
    bus_stop();
    push_exp("R4");

    // R5: pointer with upper bits set
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h81, 1'b1, "R5"); m_ptr = 1'b1;
    wr_data(8'h77);
    bus_stop();
    push_exp("R5");

    // R9: matched read, then bus ignored
    bus_start();
    send_byte(own(1'b1), 1'b1, "R9");
    send_byte(8'h00, 1'b0, "R9");
    bus_stop();
    push_exp("R9");

    // R2: repeated START after a pointer byte
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h00, 1'b1, "R5");
    bus_start();
    send_byte(own(1'b0), 1'b1, "R2");
    send_byte(8'h01, 1'b1, "R5"); m_ptr = 1'b1;
    wr_data(8'h5A);
    bus_stop();
    push_exp("R2");

    // R2: repeated START in the middle of a data byte
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h01, 1'b1, "R5");
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(own(1'b0), 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R5"); m_ptr = 1'b0;
    wr_data(8'h9C);
    bus_stop();
    push_exp("R2");

    // R3: new strap value moves the address
    strap_d = 2'b01;
    tick(5);
    bus_start();
    send_byte({5'b00100, 2'b10, 1'b0}, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h00, 1'b1, "R5"); m_ptr = 1'b0;
    wr_data(8'hC3);
    wr_data(8'h4B);
    bus_stop();
    push_exp("R3");

    // R10: STOP mid-byte, then clocking with no START
    bus_start();
    send_byte(own(1'b0), 1'b1, "R3");
    send_byte(8'h01, 1'b1, "R5");
    send_bits(8'hFF, 5);
    bus_stop();
    check(sda_drive_n == 1'b1, "R10", "drive after stop", 32'(sda_drive_n), 1);
    send_byte(own(1'b0), 1'b0, "R10");
    send_byte(8'h00, 1'b0, "R10");
    bus_stop();
    push_exp("R10");

    done = 1'b1;
    tick(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule